// File: doc/BRIEF.md
# Dual Wiper Register Command Controller

This block sits behind a serial bus front end and carries out the decoded commands that set two digitally controlled potentiometers. Each potentiometer owns an 8-bit volatile wiper position and a bank of four 8-bit storage registers. The storage registers behave as non-volatile memory and are modelled here as flops with a timed write cycle. The front end hands over three things: the instruction byte once it has been acknowledged, an optional data byte, and a pulse for each stop condition. The controller then reads, writes, or moves values between a wiper and its storage bank. It can also do this for both potentiometers at once, or arm an up/down stepping mode.

Writes to the storage registers take effect only when the stop condition closes a complete command. Each such write starts a busy window of `BUSY_CYCLES` system clocks, and new instructions are refused while that window is open. A low level on the protect input cancels storage writes. Loads into the wipers are not affected by it. At reset each wiper takes the value of its own register 0.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After reset, `wiper0`/`wiper1` equal storage register 0 of pot 0/pot 1 (from `DR_INIT`), `busy` is low and `rdValid` is low.
- R2: Instruction byte layout: bits [7:4] opcode, [3:2] register select, bit 1 must be 0, bit 0 pot select. Opcode 1001 (read wiper) makes `rdValid` high for one cycle, one cycle after the instruction strobe, with `rdData` equal to the selected wiper.
- R3: Opcode 1011 (read storage) returns the selected register of the selected pot in the same way as R2.
- R4: Opcode 1010 followed by a data strobe loads the data byte into the selected wiper one cycle after the data strobe, without a busy window.
- R5: Opcode 1101 copies the selected register into the selected pot's wiper. Opcode 0001 does the same for both pots at once. Both take effect one cycle after the instruction strobe.
- R6: Opcode 1100 with a data byte writes the selected register when the following stop strobe arrives. `busy` then goes high for exactly `BUSY_CYCLES` cycles.
- R7: Opcode 1110 copies the selected wiper into the selected register at the stop strobe. Opcode 1000 copies both wipers into register select of their own pots. Each starts the busy window.
- R8: While `busy` is high, instruction strobes are ignored: no read response and no register or wiper change.
- R9: With `wpN` low, a stop strobe commits no storage write and starts no busy window. Wiper loads still work.
- R10: Opcode 0010 arms stepping for the selected pot. Each `incStep` pulse moves the wiper up when `incUp` is 1 and down when it is 0, saturating at 255 and at 0. A stop strobe disarms stepping.
- R11: An unknown opcode, or a nonzero bit 1, is ignored. A storage write that is followed by a new instruction instead of a stop is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmdValid | input | 1 | Acknowledged instruction byte strobe |
| cmdByte | input | 8 | Instruction byte |
| dataValid | input | 1 | Data byte strobe for the write forms |
| dataByte | input | 8 | Data byte |
| stopSeen | input | 1 | Stop condition strobe |
| incStep | input | 1 | One stepping pulse while stepping is armed |
| incUp | input | 1 | Step direction, 1 = up |
| wpN | input | 1 | Write protect, low blocks storage writes |
| rdValid | output | 1 | Read response valid |
| rdData | output | 8 | Read response value |
| busy | output | 1 | Storage write cycle in progress |
| wiper0 | output | 8 | Wiper position of pot 0 |
| wiper1 | output | 8 | Wiper position of pot 1 |

## Verification
The read response and all wiper loads come out of one register stage. They are therefore due one cycle after the instruction or data strobe. The bench drives inputs on falling edges and samples at the next falling edge, which falls inside that cycle. Storage writes and the rise of `busy` are due one cycle after the stop strobe. The bench counts the busy window on falling edges until it drops and compares the count with the parameter. Storage contents are checked only through later read commands.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  parameter int W    = 8;
  parameter int NPOT = 2;
  parameter int NREG = 4;
  localparam int SELW = $clog2(NREG);
  localparam int POTW = $clog2(NPOT);

  typedef logic [W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_GLB_DR2W  = 4'b0001,
    OP_STEP      = 4'b0010,
    OP_GLB_W2DR  = 4'b1000,
    OP_RD_WIPER  = 4'b1001,
    OP_WR_WIPER  = 4'b1010,
    OP_RD_DR     = 4'b1011,
    OP_WR_DR     = 4'b1100,
    OP_DR2W      = 4'b1101,
    OP_W2DR      = 4'b1110
  } opcode_e;

  typedef struct packed {
    logic [NPOT-1:0] wiperLoad;
    logic            wiperFromDr;
    logic [NPOT-1:0] wiperStep;
    logic            stepUp;
    logic [NPOT-1:0] drWrite;
    logic            drFromWiper;
    logic [SELW-1:0] regSel;
    word_t           data;
    logic            rdReq;
    logic            rdFromDr;
    logic [POTW-1:0] rdPot;
    logic            startBusy;
  } strobe_t;
endpackage

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
  import dwc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmdValid,
  input  logic [7:0] cmdByte,
  input  logic    dataValid,
  input  word_t   dataByte,
  input  logic    stopSeen,
  input  logic    incStep,
  input  logic    incUp,
  input  logic    wpN,
  input  logic    busyIn,
  output strobe_t strb
);
  logic [3:0]      opIn;
  logic [SELW-1:0] selIn;
  logic [POTW-1:0] potIn;
  logic            accept, knownOp;

  logic [3:0]      pendOp;
  logic [SELW-1:0] pendSel;
  logic [POTW-1:0] pendPot;
  logic            waitData, nvPend, nvGlobal, nvFromWiper, incArmed;
  word_t           nvData;

  assign opIn   = cmdByte[7:4];
  assign selIn  = cmdByte[3:2];
  assign potIn  = cmdByte[POTW-1:0];
  assign accept = cmdValid && !busyIn;

  always_comb begin
    case (opIn)
      OP_GLB_DR2W, OP_STEP, OP_GLB_W2DR, OP_RD_WIPER, OP_WR_WIPER,
      OP_RD_DR, OP_WR_DR, OP_DR2W, OP_W2DR: knownOp = !cmdByte[1];
      default:                              knownOp = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    if (accept && knownOp) begin
      strb.regSel = selIn;
      strb.rdPot  = potIn;
      case (opIn)
        OP_RD_WIPER: strb.rdReq = 1'b1;
        OP_RD_DR:    begin strb.rdReq = 1'b1; strb.rdFromDr = 1'b1; end
        OP_DR2W:     begin strb.wiperLoad[potIn] = 1'b1; strb.wiperFromDr = 1'b1; end
        OP_GLB_DR2W: begin strb.wiperLoad = '1; strb.wiperFromDr = 1'b1; end
        default: ;
      endcase
    end else if (waitData && dataValid) begin
      if (pendOp == OP_WR_WIPER) begin
        strb.wiperLoad[pendPot] = 1'b1;
        strb.data = dataByte;
      end
    end else if (incArmed && incStep && !busyIn) begin
      strb.wiperStep[pendPot] = 1'b1;
      strb.stepUp = incUp;
    end else if (stopSeen && nvPend && wpN) begin
      strb.drWrite     = nvGlobal ? '1 : (NPOT'(1) << pendPot);
      strb.drFromWiper = nvFromWiper;
      strb.regSel      = pendSel;
      strb.data        = nvData;
      strb.startBusy   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendOp <= '0; pendSel <= '0; pendPot <= '0;
      waitData <= 1'b0; nvPend <= 1'b0; nvGlobal <= 1'b0;
      nvFromWiper <= 1'b0; incArmed <= 1'b0; nvData <= '0;
    end else begin
      if (accept) begin
        pendOp      <= knownOp ? opIn : 4'b0000;
        pendSel     <= selIn;
        pendPot     <= potIn;
        waitData    <= knownOp && (opIn == OP_WR_WIPER || opIn == OP_WR_DR);
        incArmed    <= knownOp && (opIn == OP_STEP);
        nvPend      <= knownOp && (opIn == OP_W2DR || opIn == OP_GLB_W2DR);
        nvGlobal    <= (opIn == OP_GLB_W2DR);
        nvFromWiper <= 1'b1;
      end else if (waitData && dataValid) begin
        waitData <= 1'b0;
        if (pendOp == OP_WR_DR) begin
          nvPend      <= 1'b1;
          nvGlobal    <= 1'b0;
          nvFromWiper <= 1'b0;
          nvData      <= dataByte;
        end
      end
      if (stopSeen) begin
        nvPend   <= 1'b0;
        waitData <= 1'b0;
        incArmed <= 1'b0;
      end
    end
  end

  // R9: protect low at a stop must not open a busy window
  p_wp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopSeen && !wpN && !busyIn) |=> !busyIn);

  // R8: a refused instruction leaves the pending command untouched
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busyIn && cmdValid && !stopSeen) |=> ($stable(pendOp) && $stable(incArmed)));
endmodule

// File: rtl/dwc_datapath.sv
module dwc_datapath
  import dwc_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000000,
  parameter logic [NPOT*NREG*W-1:0] DR_INIT = '0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  output logic    busy,
  output logic    rdValid,
  output word_t   rdData,
  output word_t   wiper [NPOT]
);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);
  localparam word_t WMAX = '1;

  word_t          dr [NPOT][NREG];
  logic [BCW-1:0] busyCnt;

  assign busy = (busyCnt != '0);

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper[p] <= DR_INIT[p*NREG*W +: W];
      end else if (strb.wiperLoad[p]) begin
        wiper[p] <= strb.wiperFromDr ? dr[p][strb.regSel] : strb.data;
      end else if (strb.wiperStep[p]) begin
        if (strb.stepUp && wiper[p] != WMAX)       wiper[p] <= wiper[p] + 1'b1;
        else if (!strb.stepUp && wiper[p] != '0)   wiper[p] <= wiper[p] - 1'b1;
      end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          dr[p][r] <= DR_INIT[(p*NREG+r)*W +: W];
        else if (strb.drWrite[p] && strb.regSel == SELW'(r))
          dr[p][r] <= strb.drFromWiper ? wiper[p] : strb.data;
      end
    end

    // R10: a step never wraps past either end
    p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.wiperStep[p] && !strb.wiperLoad[p] &&
       wiper[p] == (strb.stepUp ? WMAX : '0)) |=> $stable(wiper[p]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyCnt <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strb.startBusy)  busyCnt <= BCW'(BUSY_CYCLES);
      else if (busy)       busyCnt <= busyCnt - 1'b1;
      rdValid <= strb.rdReq;
      if (strb.rdReq)
        rdData <= strb.rdFromDr ? dr[strb.rdPot][strb.regSel] : wiper[strb.rdPot];
    end
  end

  // R6: storage writes never overlap a running write cycle
  p_nv_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb.drWrite) |-> !busy);
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dwc_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000000,
  parameter logic [NPOT*NREG*W-1:0] DR_INIT = 64'h7766_55C0_3322_1140
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       dataValid,
  input  logic [7:0] dataByte,
  input  logic       stopSeen,
  input  logic       incStep,
  input  logic       incUp,
  input  logic       wpN,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       busy,
  output logic [7:0] wiper0,
  output logic [7:0] wiper1
);
  strobe_t strb;
  word_t   wiperArr [NPOT];

  dwc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataValid(dataValid), .dataByte(dataByte), .stopSeen(stopSeen),
    .incStep(incStep), .incUp(incUp), .wpN(wpN), .busyIn(busy), .strb(strb)
  );

  dwc_datapath #(.BUSY_CYCLES(BUSY_CYCLES), .DR_INIT(DR_INIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busy(busy),
    .rdValid(rdValid), .rdData(rdData), .wiper(wiperArr)
  );

  assign wiper0 = wiperArr[0];
  assign wiper1 = wiperArr[1];

  // R2: read-wiper command returns pot 0 position one cycle later
  p_rd_wiper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy && cmdByte == 8'h90) |=> (rdValid && rdData == $past(wiper0)));
endmodule

// File: tb/dual_wiper_ctrl_tb.sv
module dual_wiper_ctrl_tb;
  localparam int BUSY_N = 20;
  localparam int NVEC = 14;
  // {cmd, data, hasData, expW0, expW1, expRd, chkRd}
  localparam logic [55:0] VEC [NVEC] = '{
    56'h90_00_00_40_C0_40_01,   // R2 read wiper 0
    56'h91_00_00_40_C0_C0_01,   // R2 read wiper 1
    56'hB9_00_00_40_C0_66_01,   // R3 read pot1 reg2
    56'hA0_5A_01_5A_C0_00_00,   // R4 write wiper 0
    56'hD5_00_00_5A_55_00_00,   // R5 pot1 reg1 -> wiper1
    56'hCC_9E_01_5A_55_00_00,   // R6 write pot0 reg3
    56'hBC_00_00_5A_55_9E_01,   // R6 readback
    56'hE9_00_00_5A_55_00_00,   // R7 wiper1 -> pot1 reg2
    56'hB9_00_00_5A_55_55_01,   // R7 readback
    56'h84_00_00_5A_55_00_00,   // R7 global wipers -> reg1
    56'h1C_00_00_9E_77_00_00,   // R5 global reg3 -> wipers
    56'hB4_00_00_9E_77_5A_01,   // R7 readback pot0 reg1
    56'h30_00_00_9E_77_00_00,   // R11 unknown opcode
    56'h92_00_00_9E_77_00_00    // R11 bit1 set
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmdValid = 0, dataValid = 0, stopSeen = 0, incStep = 0, incUp = 0, wpN = 1;
  logic [7:0] cmdByte = 0, dataByte = 0;
  logic rdValid, busy;
  logic [7:0] rdData, wiper0, wiper1;
  int checks = 0, errors = 0;
  logic gotRd;
  logic [7:0] gotVal;
  bit done = 0;

  always #4 clk = ~clk;

  dual_wiper_ctrl #(.BUSY_CYCLES(BUSY_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataValid(dataValid), .dataByte(dataByte), .stopSeen(stopSeen),
    .incStep(incStep), .incUp(incUp), .wpN(wpN), .rdValid(rdValid),
    .rdData(rdData), .busy(busy), .wiper0(wiper0), .wiper1(wiper1)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk); cmdValid = 1; cmdByte = b;
    @(negedge clk); cmdValid = 0;
    gotRd = rdValid; gotVal = rdData;
  endtask

  task automatic sendData(input logic [7:0] b);
    @(negedge clk); dataValid = 1; dataByte = b;
    @(negedge clk); dataValid = 0;
  endtask

  task automatic sendStop();
    @(negedge clk); stopSeen = 1;
    @(negedge clk); stopSeen = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic stepPulse(input logic up);
    @(negedge clk); incStep = 1; incUp = up;
    @(negedge clk); incStep = 0;
  endtask

  function automatic string reqOf(input logic [7:0] c);
    case (c[7:4])
      4'b1001: return "R2";
      4'b1011: return "R3";
      4'b1010: return "R4";
      4'b1101, 4'b0001: return "R5";
      4'b1100: return "R6";
      4'b1110, 4'b1000: return "R7";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 wiper0", wiper0, 8'h40);
    check("R1 wiper1", wiper1, 8'hC0);
    check("R1 busy", {7'b0, busy}, 8'h00);
    check("R1 rdValid", {7'b0, rdValid}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [55:0] v;
      v = VEC[i];
      sendCmd(v[55:48]);
      if (v[32]) sendData(v[47:40]);
      sendStop();
      waitIdle();
      check({reqOf(v[55:48]), " wiper0"}, wiper0, v[31:24]);
      check({reqOf(v[55:48]), " wiper1"}, wiper1, v[23:16]);
      check({reqOf(v[55:48]), " rdValid"}, {7'b0, gotRd}, v[7:0]);
      if (v[0]) check({reqOf(v[55:48]), " rdData"}, gotVal, v[15:8]);
    end

    // R6 busy window length
    sendCmd(8'hC0); sendData(8'h12); sendStop();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R6 busy cycles", 8'(n), 8'(BUSY_N));
    sendCmd(8'hB0);
    check("R6 readback", gotVal, 8'h12);

    // R8 commands ignored while busy
    sendCmd(8'hC4); sendData(8'hAB); sendStop();
    sendCmd(8'h90);
    check("R8 no read while busy", {7'b0, gotRd}, 8'h00);
    sendCmd(8'hA0); sendData(8'h01); sendStop();
    check("R8 wiper0 unchanged", wiper0, 8'h9E);
    waitIdle();

    // R9 protect blocks storage, not wipers
    wpN = 0;
    sendCmd(8'hC1); sendData(8'hAA); sendStop();
    check("R9 no busy", {7'b0, busy}, 8'h00);
    sendCmd(8'hA1); sendData(8'h33); sendStop();
    check("R9 wiper1 load", wiper1, 8'h33);
    wpN = 1;
    sendCmd(8'hB1);
    check("R9 reg kept", gotVal, 8'hC0);
    sendStop();

    // R11 storage write discarded without stop
    sendCmd(8'hCC); sendData(8'h44);
    sendCmd(8'h90); sendStop();
    check("R11 no busy", {7'b0, busy}, 8'h00);
    sendCmd(8'hBC);
    check("R11 reg kept", gotVal, 8'h9E);
    sendStop();

    // R10 stepping with saturation
    sendCmd(8'hA0); sendData(8'hFE); sendStop();
    sendCmd(8'h20);
    repeat (3) stepPulse(1'b1);
    check("R10 up saturate", wiper0, 8'hFF);
    stepPulse(1'b0);
    check("R10 down step", wiper0, 8'hFE);
    sendStop();
    sendCmd(8'hA1); sendData(8'h01); sendStop();
    sendCmd(8'h21);
    repeat (3) stepPulse(1'b0);
    check("R10 down saturate", wiper1, 8'h00);
    sendStop();
    stepPulse(1'b1);
    check("R10 disarmed by stop", wiper1, 8'h00);
    check("R10 other pot untouched", wiper0, 8'hFE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule